// File: doc/BRIEF.md
# Bad Block Scanner for Small-Page NAND

This block builds a bad-block map of a small-page NAND array once the chip leaves reset. After a start pulse it visits every erase block in ascending order. For each block it reads the marker byte kept in the spare area of the block's first two pages, using a simple host-side flash command port: a byte bus with separate command, address and read strobes, and a ready/busy input from the array.

A block counts as bad when either of its two marker bytes differs from FFh. The verdict goes into a one-bit-per-block register map. When the last block has been judged, `done` goes high. The rest of the system then reads the map through a registered lookup port, for example to build a remap table before any erase or program traffic is allowed.

Each page access has four parts. First comes the spare-area command 50h. Then three address bytes follow: the offset of the marker byte within the 16-byte spare area, then the low and high bytes of the page number. After that the block waits out the array's busy period and pulses one read strobe.

Top module: `bad_block_scanner`

## Requirements
- R1: After reset `done` is low, the command, address and read strobes are low, and every block reads as good (`lk_bad` = 0) on the lookup port.
- R2: Each page access starts with one command strobe carrying 50h, followed in the next three cycles by three address strobes. These carry, in order: the marker offset 05h (column 517 minus 512), the page number bits 7:0, and the page number bits 15:8 (bits 15:14 are zero).
- R3: After the third address byte the scanner waits for `fl_ready` to go low and then high again. Only then does it raise `fl_rd_en` for exactly one cycle. It never strobes a read while `fl_ready` is low. The byte is taken from `fl_rdata` in the cycle after the strobe.
- R4: Page numbers are block*16 for the first marker page and block*16+1 for the second. Blocks are visited 0 to 1023 in ascending order, so one scan makes exactly 2048 reads.
- R5: A block is recorded bad (map bit 1) when either of its two marker bytes is not FFh, including a byte with a single cleared bit. It is recorded good (map bit 0) only when both bytes are FFh.
- R6: `done` rises only after the verdict for block 1023 has been stored. It then stays high with all flash strobes low until a new start is accepted.
- R7: `lk_bad` shows the map bit of the block on `lk_addr` one clock after the address is presented (1 = bad). It is valid whenever `done` is high.
- R8: A `start` pulse that arrives while a scan is in progress is ignored. The scan continues without restarting its page sequence.
- R9: A `start` pulse while idle (including after `done`) clears the map and `done` in the next cycle and runs a complete new scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a scan when idle |
| done | output | 1 | High once the whole map is built |
| fl_io | output | 8 | Command or address byte to the flash port |
| fl_cmd_we | output | 1 | Command strobe, `fl_io` holds the command |
| fl_addr_we | output | 1 | Address strobe, `fl_io` holds an address byte |
| fl_rd_en | output | 1 | Read strobe for one data byte |
| fl_rdata | input | 8 | Byte returned the cycle after `fl_rd_en` |
| fl_ready | input | 1 | Ready (1) or busy (0) from the array |
| lk_addr | input | 10 | Block number to look up |
| lk_bad | output | 1 | Registered map bit of `lk_addr` (1 = bad) |

## Verification
A responder in the bench returns FFh markers everywhere except on a preset list of blocks. The list mixes three cases: a bad first page only, a bad second page only, and both pages bad. It also mixes marker values 00h, FEh and 7Fh, so a decision that looks at one page only or at one bit only gives a different map. The first and last blocks are on the list to catch off-by-one walking. One unread page (page 2 of a block) carries a bad marker, which shows that only pages 0 and 1 matter. The responder also checks every command byte, the column byte and the expected page sequence, and returns 00h for any other column, so a wrong offset marks every block bad. A start pulse in the middle of a scan, and a second scan after the first, separate "ignored while busy" from "restarts when idle".

// File: rtl/bbs_pkg.sv
// Package: shared constants and types for the bad block scanner.
// Assumes an 8-bit flash byte bus and a spare area that starts at column 512.
package bbs_pkg;
    localparam logic [7:0] CMD_SPARE_READ = 8'h50;   // selects the spare-area pointer
    localparam logic [7:0] MARK_GOOD      = 8'hFF;   // marker value of a good page
    localparam int         SPARE_BASE     = 512;     // first spare column
    localparam int         MARK_COLUMN    = 517;     // column holding the marker byte

    // Scanner sequencing states
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADR_COL,
        ST_ADR_LO,
        ST_ADR_HI,
        ST_WAIT_BUSY,
        ST_WAIT_READY,
        ST_READ,
        ST_CAPTURE
    } scan_state_t;
endpackage

// File: rtl/bbs_walker.sv
// Module: bbs_walker
// Keeps the current block number and which of the two marker pages is being
// read, and forms the page number sent to the flash. Assumes
// PAGES_PER_BLOCK is a power of two and the row fits in 16 bits.
module bbs_walker #(
    parameter int NUM_BLOCKS      = 1024,
    parameter int PAGES_PER_BLOCK = 16,
    localparam int BLK_W          = $clog2(NUM_BLOCKS),
    localparam int PG_W           = $clog2(PAGES_PER_BLOCK),
    localparam int ROW_W          = BLK_W + PG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,      // restart at block 0, first page
    input  logic             step,       // move to the next marker page
    output logic [BLK_W-1:0] blk,        // current block
    output logic             page_sel,   // 0: first page, 1: second page
    output logic             last_blk,   // current block is the final one
    output logic [ROW_W-1:0] row         // page number of the current access
);
    localparam logic [BLK_W-1:0] LAST = BLK_W'(NUM_BLOCKS - 1);

    // Advance page then block on each step; clear returns to the start.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            blk      <= '0;
            page_sel <= 1'b0;
        end else if (step) begin
            if (page_sel) begin
                page_sel <= 1'b0;
                blk      <= (blk == LAST) ? '0 : blk + 1'b1;
            end else begin
                page_sel <= 1'b1;
            end
        end
    end

    assign last_blk = (blk == LAST);
    assign row      = {blk, {(PG_W-1){1'b0}}, page_sel};
endmodule

// File: rtl/bbs_bitmap.sv
// Module: bbs_bitmap
// Holds one bit per block (1 = bad) with a single write port and a
// registered lookup port. Assumes clear and write are never in one cycle.
module bbs_bitmap #(
    parameter int NUM_BLOCKS = 1024,
    localparam int BLK_W     = $clog2(NUM_BLOCKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,     // mark every block good
    input  logic             wr_en,     // store a verdict
    input  logic [BLK_W-1:0] wr_blk,
    input  logic             wr_bad,
    input  logic [BLK_W-1:0] rd_blk,
    output logic             rd_bad
);
    logic [NUM_BLOCKS-1:0] map_q;

    // One flop per block, each with its own write decode.
    for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n || clear)
                map_q[i] <= 1'b0;
            else if (wr_en && (wr_blk == BLK_W'(i)))
                map_q[i] <= wr_bad;
        end
    end

    // Registered lookup read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_bad <= 1'b0;
        else
            rd_bad <= map_q[rd_blk];
    end
endmodule

// File: rtl/bbs_sequencer.sv
// Module: bbs_sequencer
// Runs the per-page flash access: spare command, three address bytes, wait
// for busy then ready, one read strobe, capture. Combines the two marker
// verdicts of a block and writes the map. Assumes the flash lowers ready
// after the last address byte and returns data the cycle after a read strobe.
module bbs_sequencer
    import bbs_pkg::*;
#(
    parameter int ROW_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             fl_ready,
    input  logic [7:0]       fl_rdata,
    input  logic [ROW_W-1:0] row,
    input  logic             page_sel,
    input  logic             last_blk,
    output logic [7:0]       fl_io,
    output logic             fl_cmd_we,
    output logic             fl_addr_we,
    output logic             fl_rd_en,
    output logic             scan_clear,   // start accepted: clear walker and map
    output logic             walk_step,
    output logic             map_we,
    output logic             map_bad,
    output logic             done
);
    localparam logic [7:0] COL_OFS = 8'(MARK_COLUMN - SPARE_BASE);

    scan_state_t state;
    logic        first_bad;   // verdict of the block's first marker page
    logic        page_bad;
    logic [15:0] row_ext;

    assign row_ext  = 16'(row);
    assign page_bad = (fl_rdata != MARK_GOOD);

    // Next-state sequencing of one page access after another.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:       if (start) state <= ST_CMD;
                ST_CMD:        state <= ST_ADR_COL;
                ST_ADR_COL:    state <= ST_ADR_LO;
                ST_ADR_LO:     state <= ST_ADR_HI;
                ST_ADR_HI:     state <= ST_WAIT_BUSY;
                ST_WAIT_BUSY:  if (!fl_ready) state <= ST_WAIT_READY;
                ST_WAIT_READY: if (fl_ready) state <= ST_READ;
                ST_READ:       state <= ST_CAPTURE;
                ST_CAPTURE:    state <= (page_sel && last_blk) ? ST_IDLE : ST_CMD;
                default:       state <= ST_IDLE;
            endcase
        end
    end

    // Hold the first page's verdict until the second page is read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            first_bad <= 1'b0;
        else if (state == ST_CAPTURE && !page_sel)
            first_bad <= page_bad;
    end

    // Completion flag: set after the final verdict, cleared by a new start.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done <= 1'b0;
        else if (scan_clear)
            done <= 1'b0;
        else if (state == ST_CAPTURE && page_sel && last_blk)
            done <= 1'b1;
    end

    // Flash port strobes and byte bus decoded from the state register.
    always_comb begin
        fl_io      = 8'h00;
        fl_cmd_we  = 1'b0;
        fl_addr_we = 1'b0;
        fl_rd_en   = 1'b0;
        unique case (state)
            ST_CMD:     begin fl_cmd_we  = 1'b1; fl_io = CMD_SPARE_READ; end
            ST_ADR_COL: begin fl_addr_we = 1'b1; fl_io = COL_OFS;        end
            ST_ADR_LO:  begin fl_addr_we = 1'b1; fl_io = row_ext[7:0];   end
            ST_ADR_HI:  begin fl_addr_we = 1'b1; fl_io = row_ext[15:8];  end
            ST_READ:    fl_rd_en = 1'b1;
            default:    ;
        endcase
    end

    // Control toward the walker and the map.
    always_comb begin
        scan_clear = (state == ST_IDLE) && start;
        walk_step  = (state == ST_CAPTURE);
        map_we     = (state == ST_CAPTURE) && page_sel;
        map_bad    = first_bad | page_bad;
    end
endmodule

// File: rtl/bad_block_scanner.sv
// Module: bad_block_scanner (top)
// Scans all erase blocks after a start pulse, reading the spare marker of
// the first two pages of each, and keeps a bad-block map with a lookup port.
// Assumes a flash port that obeys the ready/busy handshake described in the brief.
module bad_block_scanner #(
    parameter int NUM_BLOCKS      = 1024,
    parameter int PAGES_PER_BLOCK = 16,
    localparam int BLK_W          = $clog2(NUM_BLOCKS),
    localparam int ROW_W          = BLK_W + $clog2(PAGES_PER_BLOCK)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             done,
    output logic [7:0]       fl_io,
    output logic             fl_cmd_we,
    output logic             fl_addr_we,
    output logic             fl_rd_en,
    input  logic [7:0]       fl_rdata,
    input  logic             fl_ready,
    input  logic [BLK_W-1:0] lk_addr,
    output logic             lk_bad
);
    logic [BLK_W-1:0] blk;
    logic             page_sel;
    logic             last_blk;
    logic [ROW_W-1:0] row;
    logic             scan_clear;
    logic             walk_step;
    logic             map_we;
    logic             map_bad;

    bbs_walker #(
        .NUM_BLOCKS      (NUM_BLOCKS),
        .PAGES_PER_BLOCK (PAGES_PER_BLOCK)
    ) u_walker (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (scan_clear),
        .step     (walk_step),
        .blk      (blk),
        .page_sel (page_sel),
        .last_blk (last_blk),
        .row      (row)
    );

    bbs_sequencer #(
        .ROW_W (ROW_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .fl_ready   (fl_ready),
        .fl_rdata   (fl_rdata),
        .row        (row),
        .page_sel   (page_sel),
        .last_blk   (last_blk),
        .fl_io      (fl_io),
        .fl_cmd_we  (fl_cmd_we),
        .fl_addr_we (fl_addr_we),
        .fl_rd_en   (fl_rd_en),
        .scan_clear (scan_clear),
        .walk_step  (walk_step),
        .map_we     (map_we),
        .map_bad    (map_bad),
        .done       (done)
    );

    bbs_bitmap #(
        .NUM_BLOCKS (NUM_BLOCKS)
    ) u_map (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (scan_clear),
        .wr_en  (map_we),
        .wr_blk (blk),
        .wr_bad (map_bad),
        .rd_blk (lk_addr),
        .rd_bad (lk_bad)
    );
endmodule

// File: rtl/bbs_checker.sv
// Module: bbs_checker
// Protocol and completion properties of the scanner, watched at its ports.
module bbs_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       done,
    input logic [7:0] fl_io,
    input logic       fl_cmd_we,
    input logic       fl_addr_we,
    input logic       fl_rd_en,
    input logic       fl_ready
);
    // R2: at most one strobe per cycle
    assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fl_cmd_we, fl_addr_we, fl_rd_en}));

    // R2: the only command issued is the spare-area pointer
    assert_cmd_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fl_cmd_we |-> (fl_io == 8'h50));

    // R2: the column byte with offset 5 follows every command
    assert_col_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fl_cmd_we |=> (fl_addr_we && fl_io == 8'h05));

    // R3: no read strobe while the array is busy
    assert_no_read_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fl_rd_en |-> fl_ready);

    // R6: done holds until a new start
    assert_done_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    // R6: flash port is quiet once done
    assert_quiet_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(fl_cmd_we || fl_addr_we || fl_rd_en));

    // R9: an accepted start clears done
    assert_restart_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> !done);
endmodule

bind bad_block_scanner bbs_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .done       (done),
    .fl_io      (fl_io),
    .fl_cmd_we  (fl_cmd_we),
    .fl_addr_we (fl_addr_we),
    .fl_rd_en   (fl_rd_en),
    .fl_ready   (fl_ready)
);

// File: tb/nand_spare_model.sv
// Module: nand_spare_model
// Synthesizable-style flash responder for the bench. It returns the spare
// marker of a page (FFh except on preset bad pages), models a busy period
// after the last address byte, and counts protocol violations and reads.
module nand_spare_model #(
    parameter int BUSY_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,      // reset counters and expected sequence
    input  logic [7:0] io,
    input  logic       cmd_we,
    input  logic       addr_we,
    input  logic       rd_en,
    output logic       ready,
    output logic [7:0] rdata,
    output int         viol_cnt,
    output int         read_cnt
);
    logic        spare_mode;
    logic [1:0]  acnt;
    logic [7:0]  col;
    logic [15:0] row;
    logic [15:0] exp_row;
    int          busy;

    // Marker byte of a page: preset bad pages, everything else FFh.
    function automatic logic [7:0] marker(input logic [15:0] pg);
        int b;
        int p;
        b = int'(pg) / 16;
        p = int'(pg) % 16;
        if (b == 0    && p == 0) return 8'h00;
        if (b == 3    && p == 1) return 8'h00;
        if (b == 5    && p == 2) return 8'h00;   // never read: block stays good
        if (b == 77   && p == 1) return 8'hFE;
        if (b == 200  && p == 0) return 8'h7F;
        if (b == 512  && p == 0) return 8'h00;
        if (b == 1023)           return 8'h00;
        return 8'hFF;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            spare_mode <= 1'b0;
            acnt       <= '0;
            col        <= '0;
            row        <= '0;
            exp_row    <= '0;
            busy       <= 0;
            ready      <= 1'b1;
            rdata      <= 8'h00;
            viol_cnt   <= 0;
            read_cnt   <= 0;
        end else begin
            if (cmd_we) begin
                spare_mode <= (io == 8'h50);
                acnt       <= '0;
                if (io != 8'h50) viol_cnt <= viol_cnt + 1;
            end else if (addr_we) begin
                acnt <= acnt + 1'b1;
                if (acnt == 2'd0) begin
                    col <= io;
                    if (io != 8'h05) viol_cnt <= viol_cnt + 1;
                end else if (acnt == 2'd1) begin
                    row[7:0] <= io;
                end else begin
                    row[15:8] <= io;
                    ready     <= 1'b0;
                    busy      <= BUSY_CYC;
                    if ({io, row[7:0]} != exp_row) viol_cnt <= viol_cnt + 1;
                end
            end else if (rd_en) begin
                read_cnt <= read_cnt + 1;
                rdata    <= (spare_mode && col == 8'h05) ? marker(row) : 8'h00;
                exp_row  <= row[0] ? row + 16'd15 : row + 16'd1;
                if (!ready) viol_cnt <= viol_cnt + 1;
            end
            if (!ready) begin
                if (busy <= 1) ready <= 1'b1;
                busy <= busy - 1;
            end
        end
    end
endmodule

// File: tb/sim_bad_block_scanner.sv
// Bench: scoreboard of map lookups plus responder statistics.
module sim_bad_block_scanner;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       done;
    logic [7:0] fl_io;
    logic       fl_cmd_we, fl_addr_we, fl_rd_en;
    logic [7:0] fl_rdata;
    logic       fl_ready;
    logic [9:0] lk_addr = '0;
    logic       lk_bad;
    logic       restart = 1'b0;
    int         viol_cnt, read_cnt;

    int vectors  = 0;
    int failures = 0;

    int    q_blk[$];
    bit    q_exp[$];
    string q_tag[$];

    always #4 clk = ~clk;   // 125 MHz

    bad_block_scanner u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .done(done),
        .fl_io(fl_io), .fl_cmd_we(fl_cmd_we), .fl_addr_we(fl_addr_we),
        .fl_rd_en(fl_rd_en), .fl_rdata(fl_rdata), .fl_ready(fl_ready),
        .lk_addr(lk_addr), .lk_bad(lk_bad)
    );

    nand_spare_model u_flash (
        .clk(clk), .rst_n(rst_n), .restart(restart), .io(fl_io),
        .cmd_we(fl_cmd_we), .addr_we(fl_addr_we), .rd_en(fl_rd_en),
        .ready(fl_ready), .rdata(fl_rdata),
        .viol_cnt(viol_cnt), .read_cnt(read_cnt)
    );

    function automatic bit exp_bad(input int b);
        return (b == 0 || b == 3 || b == 77 || b == 200 || b == 512 || b == 1023);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Driver: present one lookup address and queue its expected bit.
    task automatic probe(input int b, input bit e, input string tag);
        @(negedge clk);
        lk_addr = 10'(b);
        q_blk.push_back(b);
        q_exp.push_back(e);
        q_tag.push_back(tag);
    endtask

    // Monitor: compare the registered lookup result after each edge.
    always @(posedge clk) begin
        #2;
        if (q_blk.size() > 0) begin
            int    b;
            bit    e;
            string t;
            b = q_blk.pop_front();
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            vectors++;
            if (lk_bad !== e) begin
                failures++;
                $display("FAIL %s block %0d: actual %0d expected %0d", t, b, lk_bad, e);
            end
        end
    end

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    task automatic check_map(input string tag);
        for (int b = 0; b < 1024; b++) probe(b, exp_bad(b), tag);
        @(negedge clk);
        @(negedge clk);
    endtask

    // Watchdog: a hung run is one failed check and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        vectors++;
        $display("FAIL R6 watchdog: actual done=%0d expected done=1", done);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, failures);
        $finish;
    end

    initial begin
        int strobes;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(done == 1'b0, "R1 done after reset", done, 0);
        check({fl_cmd_we, fl_addr_we, fl_rd_en} == 3'b000, "R1 strobes after reset",
              {fl_cmd_we, fl_addr_we, fl_rd_en}, 0);
        probe(0, 1'b0, "R1 map clear");
        probe(1023, 1'b0, "R1 map clear");
        probe(512, 1'b0, "R1 map clear");
        @(negedge clk);

        // First scan, with a stray start in the middle (R8)
        pulse_start();
        repeat (300) @(negedge clk);
        pulse_start();
        wait_done();
        check(read_cnt == 2048, "R4/R6 reads when done first seen", read_cnt, 2048);
        check(viol_cnt == 0, "R2/R3/R4/R8 flash protocol violations", viol_cnt, 0);

        // R5/R7: whole map through the lookup port
        check_map("R5 map");
        probe(77, 1'b1, "R7 lookup latency");
        probe(78, 1'b0, "R7 lookup latency");
        probe(5, 1'b0, "R5 unread page ignored");
        @(negedge clk);

        // R6: quiet and holding after done
        strobes = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (fl_cmd_we || fl_addr_we || fl_rd_en) strobes++;
        end
        check(strobes == 0, "R6 strobes after done", strobes, 0);
        check(done == 1'b1, "R6 done holds", done, 1);

        // R9: new scan after done clears map and done
        @(negedge clk);
        restart = 1'b1;
        start   = 1'b1;
        @(negedge clk);
        restart = 1'b0;
        start   = 1'b0;
        check(done == 1'b0, "R9 done cleared", done, 0);
        probe(0, 1'b0, "R9 map cleared");
        probe(1023, 1'b0, "R9 map cleared");
        wait_done();
        check(read_cnt == 2048, "R9 reads in second scan", read_cnt, 2048);
        check(viol_cnt == 0, "R9 protocol violations in second scan", viol_cnt, 0);
        check_map("R9 map rebuilt");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, failures);
        $finish;
    end
endmodule